// File: doc/BRIEF.md
# Period-Scheduled Multichannel Sample Mixer

This block mixes up to eight sample channels into a stereo stream. Each channel steps through its samples at its own period, counted in master ticks with a fractional part. The scheduler keeps the time of the latest processed event and always serves the channel that is due soonest. It fetches only that channel's next sample over a request/acknowledge port, scales the sample by the channel volume and routes it by the channel pan. It then corrects the left and right running mixes: the channel's previous contribution comes out and the new one goes in.

Before it serves an event, the scheduler writes the mix that held since the previous event into a 512-entry stereo ring, one entry per master tick that mix stayed valid. The output side pops one entry per master-tick strobe. When the ring is full, the scheduler waits. When the ring is empty, the output repeats its last value and flags an underrun.

Top module: `smix_core`

## Requirements
- R1: After reset, `out_l`, `out_r` and `underrun` are 0, `fetch_req` is low, and every channel period is 0.
- R2: A register write with `reg_field` 0 sets the period, a 24-bit value in master ticks with 8 fraction bits. Code 1 sets the volume, an unsigned 8-bit value. Code 2 sets the pan: bit 0 routes to left, bit 1 routes to right. A channel with period 0 is inactive and is never fetched. Writing a nonzero period to an inactive channel makes it due at the current mix tick.
- R3: Each sample event is due at the integer part of its channel's next time. Events are served in order of due tick, and ties go to the lowest channel index. Each served event advances that channel's next time by its period, which is at least 1.0 tick.
- R4: `fetch_req` stays high with `fetch_ch` unchanged until `fetch_ack`. The sample on `fetch_data` is taken in the acknowledge cycle, and the request drops in the following cycle.
- R5: A channel's contribution is floor(sample × volume / 256). It goes to the left mix if pan bit 0 is set and to the right mix if pan bit 1 is set. A new sample replaces that channel's previous contribution in both mixes.
- R6: Ring entry k, counted from reset, holds the mix after all events due at or before tick k.
- R7: The 20-bit mixes are clamped to the signed 16-bit range when written to the ring.
- R8: Nothing is written while the ring holds 512 entries, and no entry is lost or overwritten.
- R9: A cycle with `tick` high and a non-empty ring moves the oldest entry to `out_l`/`out_r` at that clock edge. Without `tick`, the outputs hold.
- R10: A `tick` with an empty ring leaves the outputs unchanged and sets `underrun`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 3 | Channel addressed by the write |
| reg_field | input | 2 | 0 period, 1 volume, 2 pan |
| reg_wdata | input | 24 | Write data, right-aligned |
| fetch_req | output | 1 | Sample request |
| fetch_ch | output | 3 | Channel whose sample is requested |
| fetch_ack | input | 1 | Sample delivered this cycle |
| fetch_data | input | 16 | Signed sample |
| tick | input | 1 | Master-tick read strobe of the output side |
| out_l | output | 16 | Left output sample |
| out_r | output | 16 | Right output sample |
| underrun | output | 1 | Sticky empty-ring flag |

## Verification
The first pattern runs five channels with unrelated fractional periods, mixed pans and one muted channel. A sixth channel has only its volume written. This tells apart a wrong fetch order, a lost tie between two channels with the same period, an inactive channel being served, and a wrong replacement of old contributions. The second pattern drives four lock-stepped channels with full-scale samples of alternating sign, which pushes the mix past both 16-bit limits and separates clamping from wraparound. Each run first lets the ring fill, then drains it steadily, and finally withholds a fetch so that the ring runs dry. This exposes a stall on a full ring, the exact entry count and the sticky underrun hold.

// File: rtl/smix_pkg.sv
package smix_pkg;
  localparam logic [1:0] FLD_PERIOD = 2'd0;
  localparam logic [1:0] FLD_VOLUME = 2'd1;
  localparam logic [1:0] FLD_PAN    = 2'd2;

  typedef enum logic [1:0] {
    ST_PICK  = 2'd0,
    ST_EMIT  = 2'd1,
    ST_FETCH = 2'd2,
    ST_APPLY = 2'd3
  } sched_st_e;
endpackage

// File: rtl/smix_regs.sv
module smix_regs
  import smix_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CHW = 3,
  parameter int PW  = 24,
  parameter int VW  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [CHW-1:0]           ch,
  input  logic [1:0]               fld,
  input  logic [PW-1:0]            wdata,
  output logic [NCH-1:0][PW-1:0]   per_o,
  output logic [NCH-1:0][VW-1:0]   vol_o,
  output logic [NCH-1:0][1:0]      pan_o,
  output logic [NCH-1:0]           start_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = we && (ch == CHW'(g));
    // a channel wakes up when it leaves the all-zero period
    assign start_o[g] = hit && (fld == FLD_PERIOD) && (per_o[g] == '0) && (wdata != '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        per_o[g] <= '0;
        vol_o[g] <= '0;
        pan_o[g] <= '0;
      end else if (hit) begin
        case (fld)
          FLD_PERIOD: per_o[g] <= wdata;
          FLD_VOLUME: vol_o[g] <= wdata[VW-1:0];
          FLD_PAN:    pan_o[g] <= wdata[1:0];
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smix_pick.sv
module smix_pick #(
  parameter int NCH = 8,
  parameter int CHW = 3,
  parameter int TKW = 24
) (
  input  logic [NCH-1:0]           act,
  input  logic [NCH-1:0][TKW-1:0]  due,
  output logic                     any_o,
  output logic [CHW-1:0]           idx_o,
  output logic [TKW-1:0]           due_o
);
  // earliest due tick; strict compare keeps the lowest index on ties
  always_comb begin
    logic [TKW-1:0] d;
    any_o = 1'b0;
    idx_o = '0;
    due_o = '0;
    for (int i = 0; i < NCH; i++) begin
      d = due[i] - due_o;
      if (act[i] && (!any_o || d[TKW-1])) begin
        any_o = 1'b1;
        idx_o = CHW'(i);
        due_o = due[i];
      end
    end
  end
endmodule

// File: rtl/smix_ring.sv
module smix_ring #(
  parameter int DEPTH = 512,
  parameter int DW    = 16,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] in_l,
  input  logic [DW-1:0] in_r,
  input  logic          tick,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r,
  output logic          underrun,
  output logic          full,
  output logic [AW:0]   fill
);
  logic [2*DW-1:0] mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [2*DW-1:0] rd_q;
  logic            do_push, do_pop;

  assign full    = (fill == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = tick && (fill != '0);
  assign out_l   = rd_q[2*DW-1:DW];
  assign out_r   = rd_q[DW-1:0];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= {in_l, in_r};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (do_pop) rd_q <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      fill     <= '0;
      underrun <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      fill <= fill + (AW+1)'(do_push) - (AW+1)'(do_pop);
      if (tick && (fill == '0)) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/smix_core.sv
module smix_core
  import smix_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int SW    = 16,
  parameter int VW    = 8,
  parameter int PW    = 24,
  parameter int FRAC  = 8,
  parameter int TW    = 32,
  parameter int MW    = 20,
  parameter int DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_we,
  input  logic [$clog2(NCH)-1:0]   reg_ch,
  input  logic [1:0]               reg_field,
  input  logic [PW-1:0]            reg_wdata,
  output logic                     fetch_req,
  output logic [$clog2(NCH)-1:0]   fetch_ch,
  input  logic                     fetch_ack,
  input  logic [SW-1:0]            fetch_data,
  input  logic                     tick,
  output logic [SW-1:0]            out_l,
  output logic [SW-1:0]            out_r,
  output logic                     underrun
);
  localparam int CHW = $clog2(NCH);
  localparam int TKW = TW - FRAC;
  localparam int AW  = $clog2(DEPTH);
  localparam int PRW = SW + VW + 1;

  logic [NCH-1:0][PW-1:0]  per;
  logic [NCH-1:0][VW-1:0]  vol;
  logic [NCH-1:0][1:0]     pan;
  logic [NCH-1:0]          start;
  logic [NCH-1:0]          act;
  logic [NCH-1:0][TKW-1:0] due;
  logic [TW-1:0]           nxt   [NCH];
  logic signed [MW-1:0]    old_l [NCH];
  logic signed [MW-1:0]    old_r [NCH];

  sched_st_e               st;
  logic [CHW-1:0]          cur;
  logic [TKW-1:0]          last_tick;
  logic [TKW-1:0]          rem;
  logic signed [SW-1:0]    smp;
  logic signed [MW-1:0]    mix_l, mix_r;

  logic                    pk_any;
  logic [CHW-1:0]          pk_idx;
  logic [TKW-1:0]          pk_due;
  logic [TKW-1:0]          gap;

  logic                    push, full;
  logic [AW:0]             ring_fill;
  logic [SW-1:0]           sat_l, sat_r;

  logic signed [PRW-1:0]   prod;
  logic signed [MW-1:0]    q, new_l, new_r;

  smix_regs #(.NCH(NCH), .CHW(CHW), .PW(PW), .VW(VW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .ch(reg_ch), .fld(reg_field),
    .wdata(reg_wdata), .per_o(per), .vol_o(vol), .pan_o(pan), .start_o(start)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign act[g] = (per[g] != '0);
    assign due[g] = nxt[g][TW-1:FRAC];

    always_ff @(posedge clk) begin
      if (rst) begin
        nxt[g]   <= '0;
        old_l[g] <= '0;
        old_r[g] <= '0;
      end else if (start[g]) begin
        nxt[g] <= {last_tick, {FRAC{1'b0}}};
      end else if (st == ST_APPLY && cur == CHW'(g)) begin
        nxt[g]   <= nxt[g] + {{(TW-PW){1'b0}}, per[g]};
        old_l[g] <= new_l;
        old_r[g] <= new_r;
      end
    end
  end

  smix_pick #(.NCH(NCH), .CHW(CHW), .TKW(TKW)) u_pick (
    .act(act), .due(due), .any_o(pk_any), .idx_o(pk_idx), .due_o(pk_due)
  );

  // scaled, routed contribution of the sample just fetched
  assign prod  = smp * $signed({1'b0, vol[cur]});
  assign q     = {{(MW-SW-1){prod[PRW-1]}}, prod[PRW-1:VW]};
  assign new_l = pan[cur][0] ? q : '0;
  assign new_r = pan[cur][1] ? q : '0;
  assign gap   = pk_due - last_tick;

  function automatic logic [SW-1:0] clamp(input logic signed [MW-1:0] v);
    logic signed [MW-1:0] hi, lo;
    hi = MW'((1 << (SW-1)) - 1);
    lo = -hi - 1;
    if (v > hi)      return {1'b0, {(SW-1){1'b1}}};
    else if (v < lo) return {1'b1, {(SW-1){1'b0}}};
    else             return v[SW-1:0];
  endfunction

  assign sat_l = clamp(mix_l);
  assign sat_r = clamp(mix_r);
  assign push  = (st == ST_EMIT) && (rem != '0) && !full;
  assign fetch_ch = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PICK;
      cur       <= '0;
      last_tick <= '0;
      rem       <= '0;
      smp       <= '0;
      mix_l     <= '0;
      mix_r     <= '0;
      fetch_req <= 1'b0;
    end else begin
      case (st)
        ST_PICK: begin
          if (pk_any) begin
            cur <= pk_idx;
            rem <= gap[TKW-1] ? '0 : gap;
            st  <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (rem == '0) begin
            fetch_req <= 1'b1;
            st        <= ST_FETCH;
          end else if (!full) begin
            rem       <= rem - 1'b1;
            last_tick <= last_tick + 1'b1;
          end
        end
        ST_FETCH: begin
          if (fetch_ack) begin
            smp       <= fetch_data;
            fetch_req <= 1'b0;
            st        <= ST_APPLY;
          end
        end
        ST_APPLY: begin
          mix_l <= mix_l - old_l[cur] + new_l;
          mix_r <= mix_r - old_r[cur] + new_r;
          st    <= ST_PICK;
        end
        default: st <= ST_PICK;
      endcase
    end
  end

  smix_ring #(.DEPTH(DEPTH), .DW(SW), .AW(AW)) u_ring (
    .clk(clk), .rst(rst), .push(push), .in_l(sat_l), .in_r(sat_r),
    .tick(tick), .out_l(out_l), .out_r(out_r), .underrun(underrun),
    .full(full), .fill(ring_fill)
  );
endmodule

// File: rtl/smix_chk.sv
module smix_chk #(
  parameter int CHW   = 3,
  parameter int SW    = 16,
  parameter int AW    = 9,
  parameter int DEPTH = 512
) (
  input logic           clk,
  input logic           rst,
  input logic           fetch_req,
  input logic           fetch_ack,
  input logic [CHW-1:0] fetch_ch,
  input logic           tick,
  input logic [SW-1:0]  out_l,
  input logic [SW-1:0]  out_r,
  input logic           underrun,
  input logic           push,
  input logic [AW:0]    fill
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_ch)); // R4
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    fetch_req && fetch_ack |=> !fetch_req); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> fill < (AW+1)'(DEPTH)); // R8
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill <= (AW+1)'(DEPTH)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(out_l) && $stable(out_r)); // R9
  AST_DRY_FLAG: assert property (@(posedge clk) disable iff (rst)
    tick && fill == '0 |=> underrun && $stable(out_l) && $stable(out_r)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun); // R10
endmodule

bind smix_core smix_chk #(.CHW(CHW), .SW(SW), .AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
  .fetch_ch(fetch_ch), .tick(tick), .out_l(out_l), .out_r(out_r),
  .underrun(underrun), .push(push), .fill(ring_fill)
);

// File: tb/smix_core_bench.sv
module smix_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_ch = '0;
  logic [1:0]  reg_field = '0;
  logic [23:0] reg_wdata = '0;
  logic        fetch_req;
  logic [2:0]  fetch_ch;
  logic        fetch_ack = 1'b0;
  logic [15:0] fetch_data = '0;
  logic        tick = 1'b0;
  logic [15:0] out_l, out_r;
  logic        underrun;

  smix_core u_smix_core (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_ch(reg_ch),
    .reg_field(reg_field), .reg_wdata(reg_wdata), .fetch_req(fetch_req),
    .fetch_ch(fetch_ch), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .tick(tick), .out_l(out_l), .out_r(out_r), .underrun(underrun)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int scen;
  int cfg_per[8], cfg_vol[8], cfg_pan[8];
  int ev_ch[8192], ev_tick[8192];
  int ent_l[4096], ent_r[4096];
  int j, n_lim, pidx;
  bit ack_en = 0, stop = 0, n_set = 0, cmp_on = 0;
  int el, er, eu;
  string tag;

  function automatic int sfun(int s, int c, int n);
    if (s == 0) return ((c * 7919 + n * 1237) % 20011) - 10005;
    return (n % 2 == 0) ? 32767 : -32768;
  endfunction

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: per-tick event walk (R3, R5, R6, R7)
  task automatic build();
    int nx[8], cnt[8], ol[8], orr[8];
    int ml, mr, ne, smpv, qv, nl, nr;
    ml = 0; mr = 0; ne = 0;
    for (int c = 0; c < 8; c++) begin nx[c] = 0; cnt[c] = 0; ol[c] = 0; orr[c] = 0; end
    for (int k = 0; k < 4096; k++) begin
      for (int c = 0; c < 8; c++) begin
        if (cfg_per[c] != 0 && (nx[c] >> 8) == k) begin
          smpv = sfun(scen, c, cnt[c]);
          qv = (smpv * cfg_vol[c]) >>> 8;
          nl = cfg_pan[c][0] ? qv : 0;
          nr = cfg_pan[c][1] ? qv : 0;
          ml += nl - ol[c]; ol[c] = nl;
          mr += nr - orr[c]; orr[c] = nr;
          if (ne < 8192) begin ev_ch[ne] = c; ev_tick[ne] = k; end
          ne++;
          cnt[c]++;
          nx[c] += cfg_per[c];
        end
      end
      ent_l[k] = sat16(ml);
      ent_r[k] = sat16(mr);
    end
  endtask

  // expected output state, advanced on each strobe edge
  always @(posedge clk) begin
    if (rst) begin
      pidx = 0; el = 0; er = 0; eu = 0;
    end else if (tick) begin
      n_lim = n_set ? ev_tick[j] : 4096;
      if (pidx < n_lim) begin
        el = ent_l[pidx]; er = ent_r[pidx]; pidx++;
      end else eu = 1;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk($signed(out_l) == el, {tag, " left"}, $signed(out_l), el);
      chk($signed(out_r) == er, {tag, " right"}, $signed(out_r), er);
      chk(int'(underrun) == eu, "R10 underrun", underrun, eu);
    end
  end

  // sample source
  int cnt_src[8];
  always @(negedge clk) begin
    if (rst) begin
      fetch_ack <= 1'b0;
      for (int c = 0; c < 8; c++) cnt_src[c] = 0;
    end else if (fetch_ack) begin
      fetch_ack <= 1'b0;
    end else if (fetch_req) begin
      if (stop) begin
        if (!n_set) n_set = 1;
        chk(fetch_ch == 3'(ev_ch[j]), "R4 held channel", fetch_ch, ev_ch[j]);
      end else if (ack_en) begin
        chk(fetch_ch == 3'(ev_ch[j]), "R2 R3 fetch order", fetch_ch, ev_ch[j]);
        fetch_data <= 16'(sfun(scen, fetch_ch, cnt_src[fetch_ch]));
        cnt_src[fetch_ch]++;
        fetch_ack <= 1'b1;
        j++;
      end
    end else if (stop && n_set) begin
      chk(1'b0, "R4 request dropped", 0, 1);
    end
  end

  task automatic wr(int ch, int fld, int data);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 3'(ch); reg_field = 2'(fld); reg_wdata = 24'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_scen(int s, int nticks);
    scen = s;
    build();
    j = 0; stop = 0; n_set = 0; ack_en = 0; cmp_on = 0;
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_l == 16'h0 && out_r == 16'h0, "R1 outputs", out_l, 0);
    chk(fetch_req == 1'b0, "R1 request", fetch_req, 0);
    chk(underrun == 1'b0, "R1 underrun", underrun, 0);
    cmp_on = 1;
    for (int c = 0; c < 8; c++) begin
      if (cfg_vol[c] != 0) wr(c, 1, cfg_vol[c]);
      wr(c, 2, cfg_pan[c]);
    end
    for (int c = 0; c < 8; c++) if (cfg_per[c] != 0) wr(c, 0, cfg_per[c]);
    ack_en = 1;
    repeat (6000) @(negedge clk);
    repeat (nticks) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      repeat (15) @(negedge clk);
    end
    @(posedge clk); stop = 1;
    repeat (700) begin
      @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
      repeat (14) @(negedge clk);
    end
    chk(underrun == 1'b1, "R10 flag after drain", underrun, 1);
    cmp_on = 0; ack_en = 0;
  endtask

  initial begin
    // pattern A: fractional periods, a tie (ch0/ch3), muted and idle channels
    for (int c = 0; c < 8; c++) begin cfg_per[c] = 0; cfg_vol[c] = 0; cfg_pan[c] = 0; end
    cfg_per[0] = 'h380; cfg_vol[0] = 200; cfg_pan[0] = 3;
    cfg_per[1] = 'h540; cfg_vol[1] = 255; cfg_pan[1] = 1;
    cfg_per[2] = 'h700; cfg_vol[2] = 100; cfg_pan[2] = 2;
    cfg_per[3] = 'h380; cfg_vol[3] = 0;   cfg_pan[3] = 3;
    cfg_per[5] = 'h1C0; cfg_vol[5] = 180; cfg_pan[5] = 2;
    cfg_vol[6] = 90;                      cfg_pan[6] = 3;
    tag = "R5 R6 R8 R9";
    run_scen(0, 1000);
    // pattern B: full-scale alternating samples drive both clamps
    for (int c = 0; c < 8; c++) begin cfg_per[c] = 0; cfg_vol[c] = 0; cfg_pan[c] = 0; end
    for (int c = 0; c < 4; c++) begin cfg_per[c] = 'h200; cfg_vol[c] = 255; cfg_pan[c] = 3; end
    cfg_per[4] = 'h340; cfg_vol[4] = 128; cfg_pan[4] = 1;
    tag = "R7 R9";
    run_scen(1, 600);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule